// File: doc/BRIEF.md
# Multi-Queue Transmit Descriptor Walker

This block drives the transmit side of a network controller that keeps one buffer-descriptor ring per priority queue in system memory. Software programs a ring start address for each queue, builds two-word descriptors in memory and then pulses a start input. While transmit is enabled, the walker visits the queues from the highest-numbered one down to queue 0. It drains each queue frame by frame until it reaches a descriptor that is still marked as consumed. For every descriptor it emits one buffer segment (address, length, queue, last flag) to a downstream frame builder.

A frame may cover several descriptors. When the last descriptor of a frame has been handled, the walker sets the consumed bit in the frame's first descriptor and moves the queue's current pointer past the frame. It also raises a one-cycle completion event for that queue. Frames longer than the size limit are cut at the limit and reported. Memory is reached through a single port with one-cycle read latency. Pointer registers are written through a small queue-indexed write port.

Top module: `mq_txdesc_walker`

## Requirements
- R1: While reset is high, mem_re, mem_we, seg_valid, ev_done, ev_used and ev_trunc are all 0.
- R2: A start pulse given while tx_en is low causes no memory access, no segment and no event.
- R3: On start with tx_en high, queues are walked from queue NQ-1 down to queue 0. Each queue is drained of frames before the next lower queue is visited.
- R4: A descriptor is two 32-bit words at addresses A and A+4. Word 0 is the buffer address. In word 1, bit 31 is consumed, bit 30 is wrap, bit 15 is last-of-frame and bits 13:0 are the length. Each descriptor produces one segment with seg_addr = word 0, seg_len = the length, seg_q = the queue and seg_last = bit 15.
- R5: After a descriptor at A, the next one is read at A+8, or at the queue's ring start when bit 30 is set. After a frame, the queue's current pointer points at the descriptor that follows the frame's last one.
- R6: At the end of a frame, exactly one write is issued: to the first descriptor's word 1, with bit 31 set and all other bits unchanged. The other descriptors of the frame are not written.
- R7: Reading a descriptor whose bit 31 is set pulses ev_used for that queue, emits no segment, leaves the queue's pointer unchanged and moves on to the next lower queue. A repeated start therefore sees the same descriptor again.
- R8: ev_done pulses once for the queue for each completed frame.
- R9: The segment lengths of one frame add up to at most 2048. The segment that crosses the limit is cut to the remainder. Later non-last descriptors of that frame, and zero-length non-last descriptors, emit nothing. A last descriptor always emits a segment, possibly of length 0. A cut frame pulses ev_trunc together with ev_done.
- R10: While tx_en is low, every queue's current pointer is held at its ring start. If tx_en is low when a descriptor's second word arrives, the walk stops with no segment, no write and no event.
- R11: A pointer write for queue q sets both that queue's ring start and its current pointer to the written address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_en | input | 1 | Transmit enable level |
| start | input | 1 | Start-walk pulse |
| ptr_wr | input | 1 | Pointer write strobe |
| ptr_wr_q | input | QW | Queue selected by the pointer write |
| ptr_wr_addr | input | AW | Ring start address written |
| mem_re | output | 1 | Memory read request |
| mem_we | output | 1 | Memory write request |
| mem_addr | output | AW | Byte address of the memory word |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Read data, valid the cycle after mem_re is sampled |
| seg_valid | output | 1 | Segment strobe |
| seg_addr | output | AW | Segment buffer address |
| seg_len | output | LENW | Segment length in bytes |
| seg_q | output | QW | Queue of the segment |
| seg_last | output | 1 | Segment ends its frame |
| ev_done | output | NQ | Per-queue frame-complete pulse |
| ev_used | output | NQ | Per-queue consumed-descriptor pulse |
| ev_trunc | output | NQ | Per-queue frame-cut pulse |

## Verification
The hardest case to reach from the ports is the abort on a cleared transmit enable. The enable must drop after the walk has started but before the second descriptor word has been checked, a window of only a few cycles. The bench counts clock edges from the start pulse and releases tx_en at a fixed negative edge inside that window. It then restarts and expects the same frame from the ring start. A second hard case is a pointer parked on a consumed descriptor after a full drain. This is reached by restoring fresh descriptors without toggling the enable and checking that only consumed-descriptor events appear.

// File: rtl/mqtw_pkg.sv
package mqtw_pkg;
  localparam int DW        = 32;
  localparam int USED_BIT  = 31;
  localparam int WRAP_BIT  = 30;
  localparam int LAST_BIT  = 15;
  localparam int DESC_STEP = 8;
  localparam int W1_OFS    = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR0,
    ST_ADDR1,
    ST_EVAL,
    ST_WBACK
  } walk_st_t;
endpackage

// File: rtl/mqtw_ptr_bank.sv
module mqtw_ptr_bank #(
  parameter int NQ = 4,
  parameter int AW = 32,
  parameter int QW = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tx_en,
  input  logic             wr_en,
  input  logic [QW-1:0]    wr_q,
  input  logic [AW-1:0]    wr_addr,
  input  logic             adv_en,
  input  logic [QW-1:0]    adv_q,
  input  logic [AW-1:0]    adv_ptr,
  output logic [NQ*AW-1:0] cur_flat,
  output logic [NQ*AW-1:0] base_flat
);
  // one ring-start / current-pointer pair per queue
  for (genvar gi = 0; gi < NQ; gi++) begin : g_q
    logic [AW-1:0] base_r;
    logic [AW-1:0] cur_r;

    always_ff @(posedge clk) begin
      if (rst) begin
        base_r <= '0;
        cur_r  <= '0;
      end else if (wr_en && wr_q == QW'(gi)) begin
        base_r <= wr_addr;
        cur_r  <= wr_addr;
      end else if (!tx_en) begin
        cur_r <= base_r;
      end else if (adv_en && adv_q == QW'(gi)) begin
        cur_r <= adv_ptr;
      end
    end

    assign cur_flat[gi*AW +: AW]  = cur_r;
    assign base_flat[gi*AW +: AW] = base_r;
  end
endmodule

// File: rtl/mqtw_len_clip.sv
module mqtw_len_clip #(
  parameter int LENW   = 14,
  parameter int MAXLEN = 2048,
  parameter int ACCW   = 12
) (
  input  logic [ACCW-1:0] acc_in,
  input  logic [LENW-1:0] len_in,
  output logic [LENW-1:0] seg_len,
  output logic [ACCW-1:0] acc_out,
  output logic            clipped
);
  localparam int CW = ((LENW > ACCW) ? LENW : ACCW) + 1;

  logic [CW-1:0] room;
  logic [CW-1:0] len_x;
  logic [CW-1:0] take;
  logic [CW-1:0] sum;

  always_comb begin
    room    = CW'(MAXLEN) - CW'(acc_in);
    len_x   = CW'(len_in);
    clipped = (len_x > room);
    take    = clipped ? room : len_x;
    sum     = CW'(acc_in) + take;
    seg_len = LENW'(take);
    acc_out = ACCW'(sum);
  end
endmodule

// File: rtl/mqtw_walk_fsm.sv
module mqtw_walk_fsm
  import mqtw_pkg::*;
#(
  parameter int NQ     = 4,
  parameter int AW     = 32,
  parameter int QW     = 2,
  parameter int LENW   = 14,
  parameter int MAXLEN = 2048
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tx_en,
  input  logic             start,
  input  logic [NQ*AW-1:0] cur_flat,
  input  logic [NQ*AW-1:0] base_flat,
  output logic             adv_en,
  output logic [QW-1:0]    adv_q,
  output logic [AW-1:0]    adv_ptr,
  output logic             mem_re,
  output logic             mem_we,
  output logic [AW-1:0]    mem_addr,
  output logic [DW-1:0]    mem_wdata,
  input  logic [DW-1:0]    mem_rdata,
  output logic             seg_valid,
  output logic [AW-1:0]    seg_addr,
  output logic [LENW-1:0]  seg_len,
  output logic [QW-1:0]    seg_q,
  output logic             seg_last,
  output logic [NQ-1:0]    ev_done,
  output logic [NQ-1:0]    ev_used,
  output logic [NQ-1:0]    ev_trunc
);
  localparam int ACCW = $clog2(MAXLEN + 1);
  localparam logic [DW-1:0] USED_MASK = DW'(1) << USED_BIT;

  walk_st_t      state;
  logic [QW-1:0] q_r;
  logic [AW-1:0] walk_r;
  logic [AW-1:0] buf_r;
  logic [AW-1:0] first_addr_r;
  logic [DW-1:0] first_w1_r;
  logic          first_r;
  logic [ACCW-1:0] acc_r;
  logic          trunc_r;

  logic [QW-1:0]   q_dn;
  logic [AW-1:0]   cur_top;
  logic [AW-1:0]   cur_dn;
  logic [AW-1:0]   base_q;
  logic [AW-1:0]   nxt_ptr;
  logic            w1_used;
  logic            w1_wrap;
  logic            w1_last;
  logic [LENW-1:0] clip_len;
  logic [ACCW-1:0] clip_acc;
  logic            clip_hit;

  always_comb begin
    q_dn    = q_r - 1'b1;
    cur_top = cur_flat[(NQ-1)*AW +: AW];
    cur_dn  = cur_flat[q_dn*AW +: AW];
    base_q  = base_flat[q_r*AW +: AW];
    w1_used = mem_rdata[USED_BIT];
    w1_wrap = mem_rdata[WRAP_BIT];
    w1_last = mem_rdata[LAST_BIT];
    nxt_ptr = w1_wrap ? base_q : walk_r + AW'(DESC_STEP);
  end

  mqtw_len_clip #(
    .LENW  (LENW),
    .MAXLEN(MAXLEN),
    .ACCW  (ACCW)
  ) u_clip (
    .acc_in (acc_r),
    .len_in (mem_rdata[LENW-1:0]),
    .seg_len(clip_len),
    .acc_out(clip_acc),
    .clipped(clip_hit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_IDLE;
      q_r          <= '0;
      walk_r       <= '0;
      buf_r        <= '0;
      first_addr_r <= '0;
      first_w1_r   <= '0;
      first_r      <= 1'b0;
      acc_r        <= '0;
      trunc_r      <= 1'b0;
      adv_en       <= 1'b0;
      adv_q        <= '0;
      adv_ptr      <= '0;
      mem_re       <= 1'b0;
      mem_we       <= 1'b0;
      mem_addr     <= '0;
      mem_wdata    <= '0;
      seg_valid    <= 1'b0;
      seg_addr     <= '0;
      seg_len      <= '0;
      seg_q        <= '0;
      seg_last     <= 1'b0;
      ev_done      <= '0;
      ev_used      <= '0;
      ev_trunc     <= '0;
    end else begin
      mem_re    <= 1'b0;
      mem_we    <= 1'b0;
      seg_valid <= 1'b0;
      adv_en    <= 1'b0;
      ev_done   <= '0;
      ev_used   <= '0;
      ev_trunc  <= '0;
      case (state)
        ST_IDLE: begin
          if (start && tx_en) begin
            q_r      <= QW'(NQ-1);
            walk_r   <= cur_top;
            mem_re   <= 1'b1;
            mem_addr <= cur_top;
            first_r  <= 1'b1;
            acc_r    <= '0;
            trunc_r  <= 1'b0;
            state    <= ST_ADDR0;
          end
        end
        ST_ADDR0: begin
          mem_re   <= 1'b1;
          mem_addr <= walk_r + AW'(W1_OFS);
          state    <= ST_ADDR1;
        end
        ST_ADDR1: begin
          buf_r <= mem_rdata[AW-1:0];
          state <= ST_EVAL;
        end
        ST_EVAL: begin
          if (!tx_en) begin
            state <= ST_IDLE;
          end else if (w1_used) begin
            ev_used[q_r] <= 1'b1;
            if (q_r == '0) begin
              state <= ST_IDLE;
            end else begin
              q_r      <= q_dn;
              walk_r   <= cur_dn;
              mem_re   <= 1'b1;
              mem_addr <= cur_dn;
              first_r  <= 1'b1;
              acc_r    <= '0;
              trunc_r  <= 1'b0;
              state    <= ST_ADDR0;
            end
          end else begin
            if (clip_len != '0 || w1_last) begin
              seg_valid <= 1'b1;
              seg_addr  <= buf_r;
              seg_len   <= clip_len;
              seg_q     <= q_r;
              seg_last  <= w1_last;
            end
            acc_r   <= clip_acc;
            trunc_r <= trunc_r | clip_hit;
            first_r <= 1'b0;
            if (first_r) begin
              first_addr_r <= walk_r;
              first_w1_r   <= mem_rdata;
            end
            walk_r <= nxt_ptr;
            if (w1_last) begin
              mem_we        <= 1'b1;
              mem_addr      <= (first_r ? walk_r : first_addr_r) + AW'(W1_OFS);
              mem_wdata     <= (first_r ? mem_rdata : first_w1_r) | USED_MASK;
              ev_done[q_r]  <= 1'b1;
              ev_trunc[q_r] <= trunc_r | clip_hit;
              adv_en        <= 1'b1;
              adv_q         <= q_r;
              adv_ptr       <= nxt_ptr;
              state         <= ST_WBACK;
            end else begin
              mem_re   <= 1'b1;
              mem_addr <= nxt_ptr;
              state    <= ST_ADDR0;
            end
          end
        end
        ST_WBACK: begin
          mem_re   <= 1'b1;
          mem_addr <= walk_r;
          first_r  <= 1'b1;
          acc_r    <= '0;
          trunc_r  <= 1'b0;
          state    <= ST_ADDR0;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mq_txdesc_walker.sv
module mq_txdesc_walker #(
  parameter int NQ     = 4,
  parameter int AW     = 32,
  parameter int LENW   = 14,
  parameter int MAXLEN = 2048,
  parameter int QW     = (NQ > 1) ? $clog2(NQ) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            tx_en,
  input  logic            start,
  input  logic            ptr_wr,
  input  logic [QW-1:0]   ptr_wr_q,
  input  logic [AW-1:0]   ptr_wr_addr,
  output logic            mem_re,
  output logic            mem_we,
  output logic [AW-1:0]   mem_addr,
  output logic [31:0]     mem_wdata,
  input  logic [31:0]     mem_rdata,
  output logic            seg_valid,
  output logic [AW-1:0]   seg_addr,
  output logic [LENW-1:0] seg_len,
  output logic [QW-1:0]   seg_q,
  output logic            seg_last,
  output logic [NQ-1:0]   ev_done,
  output logic [NQ-1:0]   ev_used,
  output logic [NQ-1:0]   ev_trunc
);
  logic [NQ*AW-1:0] cur_flat;
  logic [NQ*AW-1:0] base_flat;
  logic             adv_en;
  logic [QW-1:0]    adv_q;
  logic [AW-1:0]    adv_ptr;

  mqtw_ptr_bank #(
    .NQ(NQ),
    .AW(AW),
    .QW(QW)
  ) u_ptrs (
    .clk      (clk),
    .rst      (rst),
    .tx_en    (tx_en),
    .wr_en    (ptr_wr),
    .wr_q     (ptr_wr_q),
    .wr_addr  (ptr_wr_addr),
    .adv_en   (adv_en),
    .adv_q    (adv_q),
    .adv_ptr  (adv_ptr),
    .cur_flat (cur_flat),
    .base_flat(base_flat)
  );

  mqtw_walk_fsm #(
    .NQ    (NQ),
    .AW    (AW),
    .QW    (QW),
    .LENW  (LENW),
    .MAXLEN(MAXLEN)
  ) u_walk (
    .clk      (clk),
    .rst      (rst),
    .tx_en    (tx_en),
    .start    (start),
    .cur_flat (cur_flat),
    .base_flat(base_flat),
    .adv_en   (adv_en),
    .adv_q    (adv_q),
    .adv_ptr  (adv_ptr),
    .mem_re   (mem_re),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata),
    .seg_valid(seg_valid),
    .seg_addr (seg_addr),
    .seg_len  (seg_len),
    .seg_q    (seg_q),
    .seg_last (seg_last),
    .ev_done  (ev_done),
    .ev_used  (ev_used),
    .ev_trunc (ev_trunc)
  );
endmodule

// File: rtl/mq_txdesc_walker_chk.sv
module mq_txdesc_walker_chk #(
  parameter int NQ     = 4,
  parameter int LENW   = 14,
  parameter int MAXLEN = 2048
) (
  input logic            clk,
  input logic            rst,
  input logic            tx_en,
  input logic            mem_re,
  input logic            mem_we,
  input logic            wb_used_bit,
  input logic            seg_valid,
  input logic [LENW-1:0] seg_len,
  input logic [NQ-1:0]   ev_done,
  input logic [NQ-1:0]   ev_used,
  input logic [NQ-1:0]   ev_trunc
);
  logic [1:0] since_rst;

  always_ff @(posedge clk) begin
    if (rst) since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  // R6: write-back always carries the consumed bit
  a_r6_wb_sets_used: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> wb_used_bit);

  // R6: single port, never read and write together
  a_r6_no_rw_overlap: assert property (@(posedge clk) disable iff (rst)
    !(mem_re && mem_we));

  // R8: each completion comes with its write-back
  a_r8_done_with_wb: assert property (@(posedge clk) disable iff (rst)
    (|ev_done) |-> mem_we);

  // R7: at most one completion or consumed event per cycle
  a_r7_one_event: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ev_done, ev_used}));

  // R7: consumed descriptor emits no segment
  a_r7_no_seg_on_used: assert property (@(posedge clk) disable iff (rst)
    (|ev_used) |-> !seg_valid);

  // R9: cut frames are reported only at completion
  a_r9_trunc_at_done: assert property (@(posedge clk) disable iff (rst)
    (ev_trunc & ~ev_done) == '0);

  // R9: no segment longer than the limit
  a_r9_len_cap: assert property (@(posedge clk) disable iff (rst)
    seg_valid |-> (seg_len <= LENW'(MAXLEN)));

  // R10: memory goes quiet once enable has been low for a few cycles
  a_r10_disabled_quiet: assert property (@(posedge clk) disable iff (rst)
    (since_rst == 2'd3 && !tx_en && $past(!tx_en) && $past(!tx_en, 2) && $past(!tx_en, 3))
      |-> (!mem_re && !mem_we));
endmodule

bind mq_txdesc_walker mq_txdesc_walker_chk #(
  .NQ    (NQ),
  .LENW  (LENW),
  .MAXLEN(MAXLEN)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .tx_en      (tx_en),
  .mem_re     (mem_re),
  .mem_we     (mem_we),
  .wb_used_bit(mem_wdata[31]),
  .seg_valid  (seg_valid),
  .seg_len    (seg_len),
  .ev_done    (ev_done),
  .ev_used    (ev_used),
  .ev_trunc   (ev_trunc)
);

// File: tb/mq_txdesc_walker_bench.sv
`timescale 1ns/1ps
module mq_txdesc_walker_bench;
  localparam int NQ = 4;
  localparam int AW = 32;
  localparam int LENW = 14;
  localparam int QW = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tx_en = 1'b0;
  logic start = 1'b0;
  logic ptr_wr = 1'b0;
  logic [QW-1:0] ptr_wr_q = '0;
  logic [AW-1:0] ptr_wr_addr = '0;
  logic mem_re, mem_we;
  logic [AW-1:0] mem_addr;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic seg_valid, seg_last;
  logic [AW-1:0] seg_addr;
  logic [LENW-1:0] seg_len;
  logic [QW-1:0] seg_q;
  logic [NQ-1:0] ev_done, ev_used, ev_trunc;

  always #2.5 clk = ~clk;

  mq_txdesc_walker u_mq_txdesc_walker (
    .clk(clk), .rst(rst), .tx_en(tx_en), .start(start),
    .ptr_wr(ptr_wr), .ptr_wr_q(ptr_wr_q), .ptr_wr_addr(ptr_wr_addr),
    .mem_re(mem_re), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .seg_valid(seg_valid), .seg_addr(seg_addr), .seg_len(seg_len),
    .seg_q(seg_q), .seg_last(seg_last),
    .ev_done(ev_done), .ev_used(ev_used), .ev_trunc(ev_trunc)
  );

  logic [31:0] mem [256];

  always @(posedge clk) begin
    if (mem_we) mem[mem_addr[9:2]] = mem_wdata;
    if (mem_re) mem_rdata <= mem[mem_addr[9:2]];
  end

  // monitor log
  int nseg = 0, nrd = 0, nwr = 0;
  int cdone[NQ], cused[NQ], ctrunc[NQ];
  logic [48:0] slog [128];

  initial for (int i = 0; i < NQ; i++) begin cdone[i] = 0; cused[i] = 0; ctrunc[i] = 0; end

  always @(negedge clk) begin
    if (!rst) begin
      if (seg_valid && nseg < 128) begin
        slog[nseg] = {seg_q, seg_addr, 1'b0, seg_len, seg_last};
        nseg++;
      end
      if (mem_re) nrd++;
      if (mem_we) nwr++;
      for (int i = 0; i < NQ; i++) begin
        if (ev_done[i]) cdone[i]++;
        if (ev_used[i]) cused[i]++;
        if (ev_trunc[i]) ctrunc[i]++;
      end
    end
  end

  int ntot = 0, nbad = 0;
  bit fin = 1'b0;
  logic [48:0] elog [64];
  int nexp = 0;
  logic [31:0] bq [NQ];

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    ntot++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic put(input logic [31:0] a, input logic [31:0] w0, input logic [31:0] w1);
    mem[a[9:2]] = w0;
    mem[a[9:2] + 8'd1] = w1;
  endtask

  task automatic mark_used(input int q);
    put(bq[q], 32'h0, 32'h8000_0000);
  endtask

  task automatic epush(input int q, input logic [31:0] a, input int len, input bit last);
    elog[nexp] = {2'(q), a, 1'b0, 14'(len), last};
    nexp++;
  endtask

  task automatic prog(input int q, input logic [31:0] a);
    ptr_wr = 1'b1; ptr_wr_q = 2'(q); ptr_wr_addr = a;
    cyc(1);
    ptr_wr = 1'b0;
    bq[q] = a;
  endtask

  task automatic go();
    start = 1'b1;
    cyc(1);
    start = 1'b0;
    cyc(300);
  endtask

  task automatic toggle_en();
    tx_en = 1'b0;
    cyc(2);
    tx_en = 1'b1;
    cyc(1);
  endtask

  task automatic check_segs(input string tag, input int s0);
    chk({tag, " seg count"}, 64'(nseg - s0), 64'(nexp));
    for (int i = 0; i < nexp; i++)
      if (s0 + i < nseg) chk({tag, " seg"}, 64'(slog[s0 + i]), 64'(elog[i]));
  endtask

  // sweep ring layout, computed arithmetically
  function automatic int sw_nd(input int q, input int f); return ((q + f) % 3) + 1; endfunction
  function automatic int sw_len(input int q, input int f, input int d); return 16*(q+1) + 8*f + d; endfunction
  function automatic logic [31:0] sw_buf(input int q, input int f, input int d);
    return 32'h4000_0000 | (q << 16) | (f << 8) | (d << 4);
  endfunction

  task automatic build_sweep(input bit with_exp);
    for (int q = 0; q < NQ; q++) begin
      logic [31:0] a = bq[q];
      for (int f = 0; f <= q; f++)
        for (int d = 0; d < sw_nd(q, f); d++) begin
          put(a, sw_buf(q, f, d), ((d == sw_nd(q, f) - 1) ? 32'h8000 : 32'h0) | 32'(sw_len(q, f, d)));
          a += 8;
        end
      put(a, 32'h0, 32'h8000_0000);
    end
    if (with_exp) begin
      nexp = 0;
      for (int q = NQ - 1; q >= 0; q--)
        for (int f = 0; f <= q; f++)
          for (int d = 0; d < sw_nd(q, f); d++)
            epush(q, sw_buf(q, f, d), sw_len(q, f, d), d == sw_nd(q, f) - 1);
    end
  endtask

  task automatic check_sweep_wb();
    for (int q = 0; q < NQ; q++) begin
      logic [31:0] a = bq[q];
      for (int f = 0; f <= q; f++)
        for (int d = 0; d < sw_nd(q, f); d++) begin
          logic [31:0] w = ((d == sw_nd(q, f) - 1) ? 32'h8000 : 32'h0) | 32'(sw_len(q, f, d));
          if (d == 0) w |= 32'h8000_0000;
          chk("R6 write-back word", 64'(mem[a[9:2] + 8'd1]), 64'(w));
          a += 8;
        end
    end
  endtask

  int s0, w0c, r0c;
  int d0[NQ], u0[NQ], t0[NQ];

  task automatic snap();
    s0 = nseg; w0c = nwr; r0c = nrd;
    for (int i = 0; i < NQ; i++) begin d0[i] = cdone[i]; u0[i] = cused[i]; t0[i] = ctrunc[i]; end
  endtask

  task automatic finish_run();
    if (!fin) begin
      fin = 1'b1;
      $display("test done: total=%0d bad=%0d", ntot, nbad);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    nbad++;
    $display("FAIL watchdog act=timeout exp=done");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'h0;
    cyc(4);
    // R1: reset state
    chk("R1 mem_re in reset", 64'(mem_re), 0);
    chk("R1 mem_we in reset", 64'(mem_we), 0);
    chk("R1 seg_valid in reset", 64'(seg_valid), 0);
    chk("R1 events in reset", 64'({ev_done, ev_used, ev_trunc}), 0);
    rst = 1'b0;
    cyc(2);
    for (int q = 0; q < NQ; q++) prog(q, 32'(q * 256));   // R11 programming

    // R2: start ignored while disabled
    build_sweep(1'b1);
    snap();
    go();
    chk("R2 no reads when disabled", 64'(nrd - r0c), 0);
    chk("R2 no segments when disabled", 64'(nseg - s0), 0);
    chk("R2 no events when disabled", 64'(cused[0] - u0[0] + cdone[0] - d0[0]), 0);

    // R3 R4 R5 R8: full sweep, highest queue first
    tx_en = 1'b1;
    cyc(1);
    snap();
    go();
    check_segs("R3 R4 sweep order", s0);
    check_sweep_wb();
    for (int q = 0; q < NQ; q++) begin
      chk("R8 done count", 64'(cdone[q] - d0[q]), 64'(q + 1));
      chk("R7 used count", 64'(cused[q] - u0[q]), 1);
    end
    chk("R6 one write per frame", 64'(nwr - w0c), 10);

    // R7: restart sees the same consumed descriptor
    snap();
    go();
    chk("R7 no segments on restart", 64'(nseg - s0), 0);
    chk("R7 no writes on restart", 64'(nwr - w0c), 0);
    for (int q = 0; q < NQ; q++) chk("R7 used again", 64'(cused[q] - u0[q]), 1);

    // R10: pointers parked until enable toggles
    build_sweep(1'b1);
    snap();
    go();
    chk("R10 parked pointers give no segment", 64'(nseg - s0), 0);
    toggle_en();
    snap();
    go();
    check_segs("R10 pointers back at ring start", s0);

    // R5: wrap returns to ring start
    for (int q = 1; q < NQ; q++) mark_used(q);
    put(32'h000, 32'h5000_0000, 32'h8000 | 32'd40);
    put(32'h008, 32'h5000_0100, 32'h4000_8000 | 32'd50);
    put(32'h010, 32'h5000_0200, 32'h8000 | 32'd99);
    toggle_en();
    nexp = 0;
    epush(0, 32'h5000_0000, 40, 1);
    epush(0, 32'h5000_0100, 50, 1);
    snap();
    go();
    check_segs("R5 wrap", s0);
    chk("R5 wrap stops at consumed start", 64'(cused[0] - u0[0]), 1);
    chk("R5 skipped descriptor untouched", 64'(mem[5]), 64'(32'h8000 | 32'd99));
    put(32'h000, 32'h5000_0000, 32'h8000 | 32'd40);
    put(32'h008, 32'h5000_0100, 32'h4000_8000 | 32'd50);
    snap();
    go();
    check_segs("R5 pointer at ring start after wrap", s0);

    // R9: length limit
    put(32'h000, 32'h6000_0000, 32'd1500);
    put(32'h008, 32'h6000_1000, 32'd1000);
    put(32'h010, 32'h6000_2000, 32'h8000 | 32'd400);
    put(32'h018, 32'h6000_3000, 32'd1024);
    put(32'h020, 32'h6000_4000, 32'h8000 | 32'd1024);
    put(32'h028, 32'h6000_5000, 32'd0);
    put(32'h030, 32'h6000_6000, 32'h8000 | 32'd10);
    put(32'h038, 32'h0, 32'h8000_0000);
    toggle_en();
    nexp = 0;
    epush(0, 32'h6000_0000, 1500, 0);
    epush(0, 32'h6000_1000, 548, 0);
    epush(0, 32'h6000_2000, 0, 1);
    epush(0, 32'h6000_3000, 1024, 0);
    epush(0, 32'h6000_4000, 1024, 1);
    epush(0, 32'h6000_6000, 10, 1);
    snap();
    go();
    check_segs("R9 length limit", s0);
    chk("R9 trunc count", 64'(ctrunc[0] - t0[0]), 1);
    chk("R8 frames with limit", 64'(cdone[0] - d0[0]), 3);
    chk("R6 first-only write", 64'(mem[3]), 64'(32'd1000));

    // R11: programmed pointer inside a ring
    mark_used(0);
    put(32'h200, 32'h7000_0000, 32'h8000 | 32'd5);
    prog(2, 32'h218);
    put(32'h218, 32'h7000_0018, 32'h8000 | 32'd77);
    put(32'h220, 32'h0, 32'h8000_0000);
    nexp = 0;
    epush(2, 32'h7000_0018, 77, 1);
    snap();
    go();
    check_segs("R11 pointer write", s0);

    // R10: abort when enable drops mid-walk
    for (int q = 0; q < 3; q++) mark_used(q);
    put(32'h300, 32'h7300_0000, 32'h8000 | 32'd33);
    toggle_en();
    snap();
    start = 1'b1;
    cyc(1);
    start = 1'b0;
    cyc(1);
    tx_en = 1'b0;
    cyc(20);
    chk("R10 abort no segment", 64'(nseg - s0), 0);
    chk("R10 abort no write", 64'(nwr - w0c), 0);
    chk("R10 abort no event", 64'(cdone[3] - d0[3] + cused[3] - u0[3]), 0);
    tx_en = 1'b1;
    cyc(1);
    nexp = 0;
    epush(3, 32'h7300_0000, 33, 1);
    snap();
    go();
    check_segs("R10 restart after abort", s0);
    chk("R6 abort-restart write-back", 64'(mem[8'hC1]), 64'(32'h8000_8000 | 32'd33));

    finish_run();
  end
endmodule